// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital control front end of a 6-bit step attenuator with 0.5 dB steps. It produces one registered attenuation word, `atten_o`. The value is the attenuation in dB times two, so 0 means no added loss and 63 means 31.5 dB. Bit 5 is the 16 dB bit and bit 0 is the 0.5 dB bit.

A mode pin picks the source of the word:
- **Serial:** a 6-bit shift register fed from a data/clock pair.
- **Parallel:** a 6-bit bus.

In both modes the chosen source passes through one shared level-gated hold stage. While the latch enable is high the stage is transparent and the output follows its source. While the latch enable is low the last value is held. Parallel mode with latch enable tied high therefore gives direct control. Parallel mode with a latch-enable pulse gives latched control.

A synchronous power-up reset pulse loads a known word. In serial mode, or in parallel mode with latch enable high, that word is the value on the parallel bus. In parallel mode with latch enable low, two preset pins select one of four fixed words.

All control pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the serial clock is edge-detected in the system clock domain. Input edges must therefore be spaced a few system clocks apart. The latch enable should be tied high or pulled up when undriven. No valid/ready handshake is used: all pins are plain control levels.

Top module: `step_atten_ctrl`

## Requirements
- R1: A reset cycle with `ser_sel_i`=1 loads `atten_o` with `par_word_i`, whatever the value of `latch_en_i`.
- R2: A reset cycle with `ser_sel_i`=0 and `latch_en_i`=1 loads `atten_o` with `par_word_i`.
- R3: A reset cycle with `ser_sel_i`=0 and `latch_en_i`=0 loads `atten_o` from `preset_i`, where bit 1 is the high preset pin and bit 0 is the low preset pin:
  - 2'b00 gives 0;
  - 2'b10 gives 16 (8 dB);
  - 2'b01 gives 32 (16 dB);
  - 2'b11 gives 62 (31 dB).
  `par_word_i` is ignored in this case.
- R4: With `ser_sel_i`=0 and `latch_en_i`=1, `atten_o` follows `par_word_i` within 3 system clocks of a change.
- R5: While `latch_en_i` is low, `atten_o` holds its value whatever `par_word_i`, `ser_data_i` or `ser_clk_i` do. After a high-then-low pulse of `latch_en_i` in parallel mode, it holds the `par_word_i` value that was present during the pulse.
- R6: Each rising edge of `ser_clk_i` shifts `ser_data_i` into bit 0 of the shift register, with older bits moving toward bit 5. After six edges, the first bit sent sits in bit 5 (MSB first). A later `latch_en_i` pulse in serial mode transfers the whole word to `atten_o`.
- R7: With `ser_sel_i`=1 and `latch_en_i`=1, `atten_o` follows the shift register contents as bits are shifted in.
- R8: Outside a reset cycle, `preset_i` has no effect on `atten_o`.
- R9: Shifting works the same whether `latch_en_i` is high or low. Bits shifted while it is low appear at `atten_o` when it next goes high.
- R10: With `latch_en_i`=1, changing `ser_sel_i` switches `atten_o` between the parallel bus and the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-up reset pulse, active high |
| ser_sel_i | input | 1 | Interface select: 1 serial, 0 parallel |
| ser_data_i | input | 1 | Serial data in |
| ser_clk_i | input | 1 | Serial shift clock; shifts on its rising edge |
| latch_en_i | input | 1 | Level-sensitive hold-stage enable: high transparent, low hold |
| par_word_i | input | 6 | Parallel attenuation word (dB x 2) |
| preset_i | input | 2 | Power-up preset select: [1] high pin, [0] low pin |
| atten_o | output | 6 | Registered attenuation word (dB x 2) |

## Verification
Power-up is tried in every mode-pin combination. All four preset codes are applied with the parallel bus at all ones. This shows that the preset table is decoded with the right bit order and that the bus is ignored in that case.

Serial words are chosen whose bit reversal differs from the word itself, such as 0x31 and 0x06, so that a shift in the wrong direction is caught. Each word is shifted once with the latch enable low and once with it high, which tells the transparent path apart from the hold path.

Parallel values are changed while the latch is held. Preset pins are toggled with no reset. The mode pin is flipped with the latch open. Together these show that each source reaches the output only under its own gating.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int AW = 6;
  localparam int PW = 2;

  // Preset table used at power-up in latched parallel mode.
  // sel[1] is the high preset pin, sel[0] the low one.
  function automatic logic [AW-1:0] preset_word(input logic [PW-1:0] sel);
    logic [AW-1:0] w;
    case (sel)
      2'b00:   w = AW'(0);
      2'b10:   w = AW'(16);
      2'b01:   w = AW'(32);
      default: w = AW'(62);
    endcase
    return w;
  endfunction
endpackage

// File: rtl/atten_sync2.sv
module atten_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg1;

  // Reset flushes both stages with the live input, so no false edge
  // appears when reset ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= d;
      q    <= d;
    end else begin
      stg1 <= d;
      q    <= stg1;
    end
  end
endmodule

// File: rtl/atten_rise_det.sv
module atten_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk) begin
    prev <= lvl;
    if (rst) prev <= lvl;
  end

  assign pulse = lvl & ~prev & ~rst;
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] load_val,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= load_val;
    else if (shift_en) q <= {q[AW-2:0], bit_in};
  end
endmodule

// File: rtl/atten_hold_stage.sv
module atten_hold_stage #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pwr_word,
  input  logic          gate,
  input  logic          use_serial,
  input  logic [AW-1:0] ser_word,
  input  logic [AW-1:0] par_word,
  output logic [AW-1:0] q
);
  logic [AW-1:0] src;

  assign src = use_serial ? ser_word : par_word;

  always_ff @(posedge clk) begin
    if (rst)       q <= pwr_word;
    else if (gate) q <= src;
  end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_sel_i,
  input  logic          ser_data_i,
  input  logic          ser_clk_i,
  input  logic          latch_en_i,
  input  logic [AW-1:0] par_word_i,
  input  logic [PW-1:0] preset_i,
  output logic [AW-1:0] atten_o
);
  localparam int SW = AW + 4;

  logic [SW-1:0] raw_bus, sync_bus;
  logic          sel_s, data_s, sclk_s, le_s;
  logic [AW-1:0] par_s;
  logic          shift_pulse;
  logic [AW-1:0] ser_word;
  logic [AW-1:0] pwr_word;

  assign raw_bus = {ser_sel_i, ser_data_i, ser_clk_i, latch_en_i, par_word_i};

  atten_sync2 #(.W(SW)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  assign {sel_s, data_s, sclk_s, le_s, par_s} = sync_bus;

  atten_rise_det u_sclk_edge (
    .clk(clk), .rst(rst), .lvl(sclk_s), .pulse(shift_pulse)
  );

  // Power-up word taken from the live pins during the reset pulse.
  assign pwr_word = (ser_sel_i || latch_en_i) ? par_word_i : preset_word(preset_i);

  atten_shifter #(.AW(AW)) u_shift (
    .clk(clk), .rst(rst), .load_val(pwr_word), .shift_en(shift_pulse),
    .bit_in(data_s), .q(ser_word)
  );

  atten_hold_stage #(.AW(AW)) u_hold (
    .clk(clk), .rst(rst), .pwr_word(pwr_word), .gate(le_s),
    .use_serial(sel_s), .ser_word(ser_word), .par_word(par_s), .q(atten_o)
  );
endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       le_s,
  input logic       sel_s,
  input logic [5:0] par_s,
  input logic [5:0] ser_word,
  input logic       shift_pulse,
  input logic [5:0] atten_o,
  input logic       ser_sel_i,
  input logic       latch_en_i,
  input logic [1:0] preset_i
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !le_s |=> $stable(atten_o));

  assert_direct_par_R4: assert property (@(posedge clk) disable iff (rst)
    (le_s && !sel_s) |=> (atten_o == $past(par_s)));

  assert_transp_ser_R7: assert property (@(posedge clk) disable iff (rst)
    (le_s && sel_s) |=> (atten_o == $past(ser_word)));

  assert_shift_only_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !shift_pulse |=> $stable(ser_word));

  assert_preset_max_R3: assert property (@(posedge clk)
    (rst && !ser_sel_i && !latch_en_i && preset_i == 2'b11) |=> (atten_o == 6'd62));

  assert_preset_zero_R3: assert property (@(posedge clk)
    (rst && !ser_sel_i && !latch_en_i && preset_i == 2'b00) |=> (atten_o == 6'd0));
endmodule

bind step_atten_ctrl atten_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .le_s(le_s), .sel_s(sel_s), .par_s(par_s),
  .ser_word(ser_word), .shift_pulse(shift_pulse), .atten_o(atten_o),
  .ser_sel_i(ser_sel_i), .latch_en_i(latch_en_i), .preset_i(preset_i)
);

// File: tb/step_atten_ctrl_tb.sv
module step_atten_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_sel_i = 1'b0;
  logic       ser_data_i = 1'b0;
  logic       ser_clk_i = 1'b0;
  logic       latch_en_i = 1'b1;
  logic [5:0] par_word_i = 6'd0;
  logic [1:0] preset_i = 2'b00;
  logic [5:0] atten_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  step_atten_ctrl u_dut (
    .clk(clk), .rst(rst), .ser_sel_i(ser_sel_i), .ser_data_i(ser_data_i),
    .ser_clk_i(ser_clk_i), .latch_en_i(latch_en_i), .par_word_i(par_word_i),
    .preset_i(preset_i), .atten_o(atten_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    total++;
    if (atten_o !== exp) begin
      bad++;
      $display("FAIL %s: atten_o=%0d expected=%0d", tag, atten_o, exp);
    end
  endtask

  task automatic power_up(input logic sel, input logic le,
                          input logic [1:0] pre, input logic [5:0] par);
    rst = 1'b1;
    ser_sel_i = sel; latch_en_i = le; preset_i = pre; par_word_i = par;
    ser_clk_i = 1'b0; ser_data_i = 1'b0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic shift_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      ser_data_i = w[i];
      step(4);
      ser_clk_i = 1'b1;
      step(4);
      ser_clk_i = 1'b0;
      step(4);
    end
  endtask

  task automatic le_pulse();
    latch_en_i = 1'b1;
    step(5);
    latch_en_i = 1'b0;
    step(5);
  endtask

  task automatic t_power_up();
    power_up(1'b1, 1'b0, 2'b11, 6'h2A);
    check("R1 serial power-up", 6'h2A);
    step(5);
    check("R1 serial power-up held", 6'h2A);
    power_up(1'b0, 1'b1, 2'b11, 6'h15);
    check("R2 parallel LE-high power-up", 6'h15);
    power_up(1'b0, 1'b0, 2'b00, 6'h3F);
    check("R3 preset 00", 6'd0);
    power_up(1'b0, 1'b0, 2'b10, 6'h3F);
    check("R3 preset 10", 6'd16);
    power_up(1'b0, 1'b0, 2'b01, 6'h3F);
    check("R3 preset 01", 6'd32);
    power_up(1'b0, 1'b0, 2'b11, 6'h3F);
    step(4);
    check("R3 preset 11", 6'd62);
  endtask

  task automatic t_direct();
    power_up(1'b0, 1'b1, 2'b00, 6'h00);
    par_word_i = 6'h01; step(3);
    check("R4 direct 0x01", 6'h01);
    par_word_i = 6'h3F; step(3);
    check("R4 direct 0x3F", 6'h3F);
    par_word_i = 6'h20; step(3);
    check("R4 direct 0x20", 6'h20);
  endtask

  task automatic t_latched();
    latch_en_i = 1'b0; step(5);
    par_word_i = 6'h0C; step(6);
    check("R5 held while LE low", 6'h20);
    le_pulse();
    par_word_i = 6'h33; step(6);
    check("R5 latched pulse value", 6'h0C);
    preset_i = 2'b11; step(6);
    check("R8 preset ignored latched", 6'h0C);
    latch_en_i = 1'b1; step(5);
    preset_i = 2'b01; step(6);
    check("R8 preset ignored direct", 6'h33);
  endtask

  task automatic t_serial();
    latch_en_i = 1'b0; step(4);
    ser_sel_i = 1'b1; step(5);
    shift_word(6'h31);
    check("R5 shift hidden while LE low", 6'h33);
    le_pulse();
    check("R6 MSB-first word 0x31", 6'h31);
    shift_word(6'h06);
    le_pulse();
    check("R6 MSB-first word 0x06", 6'h06);
    latch_en_i = 1'b1; step(5);
    shift_word(6'h2A);
    check("R7 transparent serial", 6'h2A);
    latch_en_i = 1'b0; step(5);
    shift_word(6'h3C);
    check("R9 shift with LE low holds", 6'h2A);
    latch_en_i = 1'b1; step(5);
    check("R9 shifted bits appear", 6'h3C);
  endtask

  task automatic t_mode_switch();
    par_word_i = 6'h07;
    ser_sel_i = 1'b0; step(5);
    check("R10 switch to parallel", 6'h07);
    ser_sel_i = 1'b1; step(5);
    check("R10 switch to serial", 6'h3C);
  endtask

  initial begin
    @(negedge clk);
    t_power_up();
    t_direct();
    t_latched();
    t_serial();
    t_mode_switch();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: atten_o=%0d expected=finish", atten_o);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule